// File: doc/BRIEF.md
# Flash Erase Timeout Calculator

This block works out how long a host should wait for a single flash-card erase command that spans a given number of allocation units (AUs). Three figures taken from a card register describe a straight-line erase-time estimate: a batch erase time in whole seconds, the AU count that batch time refers to, and an upward offset in whole seconds. With the AU count of the command, the block evaluates the line, applies a one-second minimum, and adds a fixed surcharge for each end of the range that only partly covers an AU.

A controller pulses `start` with all operands valid on its input pins. The block captures them, forms the product of the batch time in milliseconds and the AU count, divides it by the batch AU count in a bit-serial restoring divider, and then pulses `done`. The millisecond result and an error flag stay on the outputs until the next result. A batch AU count of zero cannot be divided by; the block raises the error flag and falls back to the floor value plus surcharges.

Top module: `erase_timeout_calc`

## Requirements
- R1: With a non-zero batch count N, batch time E seconds, offset O seconds and AU count X, the base value in milliseconds is E*1000*X/N plus O*1000, and when that base is 1000 or more it is the reported `timeout_ms` when neither partial flag is set.
- R2: When the base value is below 1000 ms, exactly 1000 ms is used in its place, including X = 0 with O = 0.
- R3: Each asserted partial flag (`head_partial`, `tail_partial`) adds 250 ms, added after the floor of R2, so a 250 ms base with one flag gives 1250 ms.
- R4: With both flags asserted the surcharge totals 500 ms, which also covers a range whose first and last blocks lie in one shared partial AU.
- R5: The offset adds O*1000 ms without changing the slope part; with X = 0 the result is O*1000 ms when that reaches the floor.
- R6: A batch count of zero sets `div_error` to 1 with the result and yields 1000 ms plus the surcharges of R3/R4; a later valid operation returns `div_error` to 0.
- R7: `done` is high for exactly one cycle per accepted start, and `busy` is high from the cycle after an accepted start until the cycle `done` is high, in which it is low.
- R8: A `start` that arrives while `busy` is high is ignored: the operation under way finishes with its own operands and no extra `done` follows.
- R9: `timeout_ms` and `div_error` keep their values from one `done` pulse until the next, whatever the inputs do.
- R10: A non-integer quotient E*1000*X/N is rounded up to the next whole millisecond.
- R11: After reset `busy`, `done`, `div_error` are 0 and `timeout_ms` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Pulse to begin a calculation; ignored while busy |
| batch_time_s | input | 8 | Erase time of one batch, whole seconds |
| batch_aus | input | 16 | AU count that the batch time refers to |
| offset_s | input | 8 | Upward offset of the line, whole seconds |
| au_count | input | 12 | AUs covered by the erase command |
| head_partial | input | 1 | First AU is only partly erased |
| tail_partial | input | 1 | Last AU is only partly erased |
| busy | output | 1 | Calculation under way |
| done | output | 1 | One-cycle pulse when the result is updated |
| timeout_ms | output | 32 | Erase timeout in milliseconds |
| div_error | output | 1 | Batch AU count was zero for this result |

## Verification
The floor and the partial-AU surcharge are resolved in the same finishing cycle, so their order is the main risk: the bench drives a base well under one second together with one or both partial flags and expects 1250 or 1500 ms, never a surcharged value that the floor then swallows. The same collision is provoked on the zero-divisor path, where the floor replaces the quotient and the surcharges still apply. A second start is also driven in the middle of a running operation and the result is judged against the first operand set only.

// File: rtl/eto_pkg.sv
// Shared constants and the controller state type for the erase timeout
// calculator. Assumes all time arithmetic is in milliseconds.
package eto_pkg;
    localparam int unsigned MS_PER_S     = 1000;
    localparam int unsigned FLOOR_MS     = 1000;
    localparam int unsigned SURCHARGE_MS = 250;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_DIV  = 2'd2,
        ST_FIN  = 2'd3
    } eto_state_t;
endpackage

// File: rtl/eto_divider.sv
// Bit-serial restoring divider: one quotient bit per cycle, W cycles per
// division. Assumes the caller holds dividend/divisor only in the load cycle.
// A zero divisor yields an all-ones quotient; the caller must screen it.
module eto_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         valid,
    output logic [W-1:0] quotient,
    output logic         rem_nonzero
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W:0]       rem_q;
    logic [W-1:0]     quo_q;
    logic [W-1:0]     dsr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [W:0]       shifted;
    logic [W:0]       trial;

    // Shift the next dividend bit in and try the subtraction.
    always_comb begin
        shifted = {rem_q[W-1:0], quo_q[W-1]};
        trial   = shifted - {1'b0, dsr_q};
    end

    // Iterate one restoring step per cycle and flag the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dsr_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            valid <= 1'b0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= dividend;
            dsr_q <= divisor;
            cnt_q <= CNT_W'(W);
            run_q <= 1'b1;
            valid <= 1'b0;
        end else if (run_q) begin
            if (!trial[W]) begin
                rem_q <= trial;
                quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
                rem_q <= shifted;
                quo_q <= {quo_q[W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            run_q <= (cnt_q != CNT_W'(1));
            valid <= (cnt_q == CNT_W'(1));
        end else begin
            valid <= 1'b0;
        end
    end

    assign quotient    = quo_q;
    assign rem_nonzero = |rem_q;
endmodule

// File: rtl/eto_finalize.sv
// Turns the quotient into the final timeout: round up, add the offset,
// clamp to the floor, then add the partial-AU surcharges. Purely
// combinational; assumes the sum fits in W bits for the operand widths used.
module eto_finalize #(
    parameter int W     = 32,
    parameter int OFS_W = 8
) (
    input  logic [W-1:0]     quotient,
    input  logic             rem_nonzero,
    input  logic             zero_div,
    input  logic [OFS_W-1:0] offset_s,
    input  logic             head_partial,
    input  logic             tail_partial,
    output logic [W-1:0]     result_ms
);
    import eto_pkg::*;

    logic [W-1:0] slope_ms;
    logic [W-1:0] base_ms;
    logic [W-1:0] floored_ms;
    logic [W-1:0] extra_ms;

    // Build base, floor and surcharge in that order.
    always_comb begin
        slope_ms   = zero_div ? '0 : quotient + W'(rem_nonzero);
        base_ms    = zero_div ? '0 : slope_ms + W'(offset_s) * W'(MS_PER_S);
        floored_ms = (base_ms < W'(FLOOR_MS)) ? W'(FLOOR_MS) : base_ms;
        extra_ms   = (W'(head_partial) + W'(tail_partial)) * W'(SURCHARGE_MS);
        result_ms  = floored_ms + extra_ms;
    end
endmodule

// File: rtl/erase_timeout_calc.sv
// Erase timeout calculator top: captures operands on start, multiplies the
// batch time (ms) by the AU count, divides by the batch AU count and
// finalizes. Assumes operands are valid in the start cycle only.
module erase_timeout_calc #(
    parameter int ET_W  = 8,
    parameter int N_W   = 16,
    parameter int OFS_W = 8,
    parameter int AU_W  = 12,
    parameter int RES_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ET_W-1:0]  batch_time_s,
    input  logic [N_W-1:0]   batch_aus,
    input  logic [OFS_W-1:0] offset_s,
    input  logic [AU_W-1:0]  au_count,
    input  logic             head_partial,
    input  logic             tail_partial,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] timeout_ms,
    output logic             div_error
);
    import eto_pkg::*;

    eto_state_t       state_q;
    logic [ET_W-1:0]  et_q;
    logic [N_W-1:0]   n_q;
    logic [OFS_W-1:0] ofs_q;
    logic [AU_W-1:0]  au_q;
    logic             head_q;
    logic             tail_q;
    logic             zero_q;
    logic [RES_W-1:0] product;
    logic             div_load;
    logic             div_valid;
    logic [RES_W-1:0] quotient;
    logic             rem_nz;
    logic [RES_W-1:0] final_ms;

    // Product formed before the division so no precision is lost.
    assign product  = RES_W'(et_q) * RES_W'(MS_PER_S) * RES_W'(au_q);
    assign div_load = (state_q == ST_LOAD);
    assign busy     = (state_q != ST_IDLE);

    // Sequence the operation and register the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            et_q       <= '0;
            n_q        <= '0;
            ofs_q      <= '0;
            au_q       <= '0;
            head_q     <= 1'b0;
            tail_q     <= 1'b0;
            zero_q     <= 1'b0;
            done       <= 1'b0;
            timeout_ms <= '0;
            div_error  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    et_q    <= batch_time_s;
                    n_q     <= batch_aus;
                    ofs_q   <= offset_s;
                    au_q    <= au_count;
                    head_q  <= head_partial;
                    tail_q  <= tail_partial;
                    zero_q  <= (batch_aus == '0);
                    state_q <= ST_LOAD;
                end
                ST_LOAD: state_q <= ST_DIV;
                ST_DIV:  if (div_valid) state_q <= ST_FIN;
                ST_FIN: begin
                    timeout_ms <= final_ms;
                    div_error  <= zero_q;
                    done       <= 1'b1;
                    state_q    <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    eto_divider #(.W(RES_W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (div_load),
        .dividend    (product),
        .divisor     (RES_W'(n_q)),
        .valid       (div_valid),
        .quotient    (quotient),
        .rem_nonzero (rem_nz)
    );

    eto_finalize #(.W(RES_W), .OFS_W(OFS_W)) u_fin (
        .quotient     (quotient),
        .rem_nonzero  (rem_nz),
        .zero_div     (zero_q),
        .offset_s     (ofs_q),
        .head_partial (head_q),
        .tail_partial (tail_q),
        .result_ms    (final_ms)
    );
endmodule

// File: rtl/eto_checker.sv
// Port-level properties of the erase timeout calculator, bound to the top.
module eto_checker #(
    parameter int RES_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [RES_W-1:0] timeout_ms,
    input logic             div_error
);
    // R2: every result is at least the floor.
    a_r2_floor: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> timeout_ms >= RES_W'(1000));

    // R6: a zero-divisor result is the floor plus 0, 1 or 2 surcharges.
    a_r6_error_value: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_error) |-> (timeout_ms == RES_W'(1000) ||
                                 timeout_ms == RES_W'(1250) ||
                                 timeout_ms == RES_W'(1500)));

    // R7: done lasts one cycle.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: busy is low in the done cycle.
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: busy only rises in answer to a start.
    a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R9: outputs hold between results.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(timeout_ms) && $stable(div_error)));
endmodule

bind erase_timeout_calc eto_checker #(.RES_W(RES_W)) u_chk (.*);

// File: tb/erase_timeout_calc_test.sv
module erase_timeout_calc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  batch_time_s = '0;
    logic [15:0] batch_aus = '0;
    logic [7:0]  offset_s = '0;
    logic [11:0] au_count = '0;
    logic        head_partial = 1'b0;
    logic        tail_partial = 1'b0;
    logic        busy;
    logic        done;
    logic [31:0] timeout_ms;
    logic        div_error;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    erase_timeout_calc uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .batch_time_s(batch_time_s), .batch_aus(batch_aus),
        .offset_s(offset_s), .au_count(au_count),
        .head_partial(head_partial), .tail_partial(tail_partial),
        .busy(busy), .done(done), .timeout_ms(timeout_ms),
        .div_error(div_error)
    );

    // Watchdog: an overrun counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint model(input longint e, input longint n, input longint o,
                                     input longint x, input bit h, input bit t);
        longint base;
        if (n == 0) base = 0;
        else base = (e * 1000 * x + n - 1) / n + o * 1000;
        if (base < 1000) base = 1000;
        return base + 250 * (longint'(h) + longint'(t));
    endfunction

    // Run one calculation and check result, error flag and done width.
    task automatic run(input string req, input int e, input int n, input int o,
                       input int x, input bit h, input bit t);
        int waited = 0;
        @(negedge clk);
        batch_time_s = 8'(e); batch_aus = 16'(n); offset_s = 8'(o);
        au_count = 12'(x); head_partial = h; tail_partial = t; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        check({req, " result"}, timeout_ms, model(e, n, o, x, h, t));
        check({req, " div_error"}, div_error, (n == 0) ? 1 : 0);
        @(negedge clk);
        check({req, " R7 done one cycle"}, done, 0);
    endtask

    task automatic t_reset;
        check("R11 busy", busy, 0);
        check("R11 done", done, 0);
        check("R11 timeout", timeout_ms, 0);
        check("R11 div_error", div_error, 0);
    endtask

    task automatic t_linear;
        run("R1 3s/1AU x2", 3, 1, 0, 2, 0, 0);
        check("R1 value", timeout_ms, 6000);
        run("R1 large", 255, 1, 255, 4095, 0, 0);
        check("R1 large value", timeout_ms, 1044480000);
        run("R1 ratio", 5, 4, 0, 8, 0, 0);
    endtask

    task automatic t_round;
        run("R10 7s/3AU x1", 7, 3, 0, 1, 0, 0);
        check("R10 value", timeout_ms, 2334);
    endtask

    task automatic t_floor;
        run("R2 below floor", 1, 4, 0, 1, 0, 0);
        check("R2 value", timeout_ms, 1000);
        run("R2 zero AUs", 3, 1, 0, 0, 0, 0);
    endtask

    task automatic t_surcharge;
        run("R3 head after floor", 1, 4, 0, 1, 1, 0);
        check("R3 value", timeout_ms, 1250);
        run("R3 tail above floor", 3, 1, 0, 2, 0, 1);
        check("R3 tail value", timeout_ms, 6250);
    endtask

    task automatic t_both;
        run("R4 both at floor", 1, 4, 0, 1, 1, 1);
        check("R4 value", timeout_ms, 1500);
        run("R4 both above floor", 3, 1, 0, 2, 1, 1);
        check("R4 above value", timeout_ms, 6500);
    endtask

    task automatic t_offset;
        run("R5 offset", 3, 1, 2, 2, 0, 0);
        check("R5 value", timeout_ms, 8000);
        run("R5 offset only", 3, 1, 2, 0, 0, 0);
        check("R5 only value", timeout_ms, 2000);
    endtask

    task automatic t_error;
        run("R6 zero batch", 9, 0, 3, 50, 0, 1);
        check("R6 value", timeout_ms, 1250);
        check("R6 flag", div_error, 1);
        run("R6 recover", 3, 1, 0, 2, 0, 0);
        check("R6 flag cleared", div_error, 0);
    endtask

    // Second start mid-operation must not change the result or add a done.
    task automatic t_busy;
        int dones = 0;
        @(negedge clk);
        batch_time_s = 8'd3; batch_aus = 16'd1; offset_s = 8'd0;
        au_count = 12'd4; head_partial = 0; tail_partial = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7 busy after start", busy, 1);
        repeat (5) @(negedge clk);
        batch_time_s = 8'd1; au_count = 12'd1; head_partial = 1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 80; i++) begin
            if (done) begin
                dones++;
                check("R7 busy low at done", busy, 0);
                check("R8 first operands kept", timeout_ms, 12000);
            end
            @(negedge clk);
        end
        check("R8 single done", dones, 1);
    endtask

    task automatic t_hold;
        run("R9 setup", 7, 3, 1, 2, 1, 0);
        batch_time_s = 8'd200; batch_aus = 16'd0; au_count = 12'd900;
        head_partial = 1; tail_partial = 1;
        repeat (40) @(negedge clk);
        check("R9 timeout held", timeout_ms, model(7, 3, 1, 2, 1, 0));
        check("R9 error held", div_error, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_linear();
        t_round();
        t_floor();
        t_surcharge();
        t_both();
        t_offset();
        t_error();
        t_busy();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule